// File: doc/BRIEF.md
# Tower-Field Byte Multiplier

This block multiplies two bytes as elements of the 256-element binary field, where each byte is read as a nested tower of quadratic extensions rather than as a polynomial modulo one degree-8 polynomial. The innermost level is the four-element field generated by a root `w` of x^2+x+1. The middle level adjoins a root `y` of x^2+x+w. The outer level adjoins a root `z` of x^2+x+(w·y). Each level multiplies with three products of the level below (two-way Karatsuba), and it reduces by multiplying the top partial product by that level's fixed constant.

Beside the general product, the block drives a second output: its first operand times a fixed constant taken from the four-element subfield, which is chosen by a parameter. Because that constant lies in the innermost field, this path is four identical 2-bit slices with no carries between them. A parameter selects whether both results pass straight through combinationally or are captured in an output register, together with a valid flag one cycle later.

Top module: `tgf_mul`

## Requirements
- R1: Byte layout is recursive. Bits [3:0] hold the coefficient of 1 and bits [7:4] hold the coefficient of z. Within each nibble, bits [1:0] hold the coefficient of 1 and bits [3:2] hold the coefficient of y. Within each 2-bit pair, bit 0 is the coefficient of 1 and bit 1 is the coefficient of w. So 0x01 is one, 0x02 is w, 0x04 is y and 0x10 is z.
- R2: Innermost rule: w·w = w+1, so 0x02 × 0x02 = 0x03.
- R3: Middle rule: y·y = y+w, so 0x04 × 0x04 = 0x06.
- R4: Outer rule: z·z = z + w·y, so 0x10 × 0x10 = 0x18.
- R5: For every one of the 65536 operand pairs, the product equals the field product defined by R1 to R4.
- R6: The product is commutative: the result for (a,b) equals the result for (b,a).
- R7: A zero operand gives 0x00, and an operand of 0x01 returns the other operand unchanged.
- R8: The constant output equals a × K, where K is the parameter `KCONST` (0 to 3, placed in the byte as 0x00 to 0x03).
- R9: With `REG_OUT`=1, the results of the operands presented with `valid_i` high appear one clock later, with `valid_o` high. When `valid_i` is low, `valid_o` falls and both result outputs hold their previous value.
- R10: With `REG_OUT`=0, both results follow the operands in the same cycle, and `valid_o` equals `valid_i`.
- R11: With `REG_OUT`=1, an active-low reset clears `prod_o`, `kprod_o` and `valid_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are valid this cycle |
| a_i | input | 8 | First operand, tower representation |
| b_i | input | 8 | Second operand, tower representation |
| prod_o | output | 8 | a_i × b_i |
| kprod_o | output | 8 | a_i × KCONST |
| valid_o | output | 1 | Results are valid |

## Verification
The bench builds two copies side by side. One copy has `REG_OUT`=1 and `KCONST`=2, and the other has `REG_OUT`=0 and `KCONST`=3. Both share the operands, so one sweep of all 65536 pairs checks the registered timing and the combinational path at the same time. Between them the two constants cover the two nontrivial subfield multipliers, w and w+1. The full table of results is kept, which allows commutativity to be checked pair by pair without a reference model. A schoolbook reference with a generic reduction at each level, written independently of the Karatsuba structure, supplies every expected product.

// File: rtl/tgf_pkg.sv
package tgf_pkg;
  localparam int unsigned SUB_W  = 2;          // innermost field width
  localparam int unsigned MID_W  = 2 * SUB_W;  // middle field width
  localparam int unsigned BYTE_W = 2 * MID_W;  // outer field width
  localparam int unsigned KARA_N = 3;          // partial products per level
  localparam logic [MID_W-1:0] OUTER_K = 4'b1000; // w*y, outer reduction constant

  // innermost multiply: 4 AND, 3 XOR
  function automatic logic [SUB_W-1:0] sub_mul(input logic [SUB_W-1:0] a,
                                               input logic [SUB_W-1:0] b);
    logic c0, c1, c2, c3;
    c0 = a[0] & b[0];
    c1 = a[0] & b[1];
    c2 = a[1] & b[0];
    c3 = a[1] & b[1];
    return {c1 ^ c2 ^ c3, c0 ^ c3};
  endfunction

  // multiply by w: w*(a0 + a1 w) = a1 + (a0^a1) w
  function automatic logic [SUB_W-1:0] sub_by_w(input logic [SUB_W-1:0] a);
    return {a[0] ^ a[1], a[1]};
  endfunction

  // middle level multiply by outer constant w*y
  function automatic logic [MID_W-1:0] mid_by_k(input logic [MID_W-1:0] c);
    logic [SUB_W-1:0] lo, hi;
    lo = c[SUB_W-1:0];
    hi = c[MID_W-1:SUB_W];
    return {sub_by_w(lo ^ hi), hi ^ sub_by_w(hi)};
  endfunction
endpackage

// File: rtl/tgf_mul16.sv
module tgf_mul16
  import tgf_pkg::*;
(
  input  logic [MID_W-1:0] a_i,
  input  logic [MID_W-1:0] b_i,
  output logic [MID_W-1:0] p_o
);
  logic [SUB_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic [SUB_W-1:0] m_lo, m_hi, m_mid;

  assign a_lo = a_i[SUB_W-1:0];
  assign a_hi = a_i[MID_W-1:SUB_W];
  assign b_lo = b_i[SUB_W-1:0];
  assign b_hi = b_i[MID_W-1:SUB_W];

  assign m_lo  = sub_mul(a_lo, b_lo);
  assign m_hi  = sub_mul(a_hi, b_hi);
  assign m_mid = sub_mul(a_lo ^ a_hi, b_lo ^ b_hi);

  // y^2 = y + w: fold top product into both halves
  assign p_o = {m_mid ^ m_lo, m_lo ^ sub_by_w(m_hi)};
endmodule

// File: rtl/tgf_mul256.sv
module tgf_mul256
  import tgf_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  output logic [BYTE_W-1:0] p_o
);
  logic [MID_W-1:0] op_a [KARA_N];
  logic [MID_W-1:0] op_b [KARA_N];
  logic [MID_W-1:0] part [KARA_N];

  // index 0: low halves, 1: high halves, 2: half sums
  assign op_a[0] = a_i[MID_W-1:0];
  assign op_b[0] = b_i[MID_W-1:0];
  assign op_a[1] = a_i[BYTE_W-1:MID_W];
  assign op_b[1] = b_i[BYTE_W-1:MID_W];
  assign op_a[2] = a_i[MID_W-1:0] ^ a_i[BYTE_W-1:MID_W];
  assign op_b[2] = b_i[MID_W-1:0] ^ b_i[BYTE_W-1:MID_W];

  for (genvar g = 0; g < KARA_N; g++) begin : g_part
    tgf_mul16 u_m (.a_i(op_a[g]), .b_i(op_b[g]), .p_o(part[g]));
  end

  // z^2 = z + w*y
  assign p_o = {part[2] ^ part[0], part[0] ^ mid_by_k(part[1])};
endmodule

// File: rtl/tgf_ksub.sv
module tgf_ksub
  import tgf_pkg::*;
#(
  parameter int unsigned KCONST = 2
) (
  input  logic [BYTE_W-1:0] a_i,
  output logic [BYTE_W-1:0] p_o
);
  localparam int unsigned SLICES = BYTE_W / SUB_W;
  localparam logic [SUB_W-1:0] KVAL = SUB_W'(KCONST);

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [SUB_W-1:0] x;
    assign x = a_i[s*SUB_W +: SUB_W];
    if (KVAL == 2'd0) begin : g_zero
      assign p_o[s*SUB_W +: SUB_W] = '0;
    end else if (KVAL == 2'd1) begin : g_one
      assign p_o[s*SUB_W +: SUB_W] = x;
    end else if (KVAL == 2'd2) begin : g_w
      assign p_o[s*SUB_W +: SUB_W] = sub_by_w(x);
    end else begin : g_w1
      assign p_o[s*SUB_W +: SUB_W] = x ^ sub_by_w(x);
    end
  end
endmodule

// File: rtl/tgf_mul.sv
module tgf_mul
  import tgf_pkg::*;
#(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned KCONST  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  output logic [BYTE_W-1:0] prod_o,
  output logic [BYTE_W-1:0] kprod_o,
  output logic              valid_o
);
  logic [BYTE_W-1:0] prod_c;
  logic [BYTE_W-1:0] kprod_c;

  tgf_mul256 u_mul (.a_i(a_i), .b_i(b_i), .p_o(prod_c));
  tgf_ksub #(.KCONST(KCONST)) u_k (.a_i(a_i), .p_o(kprod_c));

  if (REG_OUT) begin : g_reg
    logic [BYTE_W-1:0] prod_q, kprod_q;
    logic              valid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prod_q  <= '0;
        kprod_q <= '0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) begin
          prod_q  <= prod_c;
          kprod_q <= kprod_c;
        end
      end
    end
    assign prod_o  = prod_q;
    assign kprod_o = kprod_q;
    assign valid_o = valid_q;
  end else begin : g_comb
    assign prod_o  = prod_c;
    assign kprod_o = kprod_c;
    assign valid_o = valid_i;
  end
endmodule

module tgf_mul_chk
  import tgf_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [BYTE_W-1:0] a_i,
  input logic [BYTE_W-1:0] b_i,
  input logic [BYTE_W-1:0] prod_c,
  input logic [BYTE_W-1:0] prod_o,
  input logic [BYTE_W-1:0] kprod_o,
  input logic              valid_o
);
  // R4: outer rule on the raw product
  always_comb begin
    if (a_i == 8'h10 && b_i == 8'h10)
      a_r4_z_square: assert (prod_c == 8'h18) else $error("z*z wrong");
  end

  if (REG_OUT) begin : g_seq
    logic seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= 1'b1;
    end

    a_r9_valid_lat: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
      valid_o == $past(valid_i));
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
      !$past(valid_i) |-> ($stable(prod_o) && $stable(kprod_o)));
    a_r7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
      $past(valid_i && (a_i == 8'h00 || b_i == 8'h00)) |-> prod_o == 8'h00);
    a_r7_ident: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
      $past(valid_i && b_i == 8'h01) |-> prod_o == $past(a_i));
    a_r8_kzero: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
      $past(valid_i && a_i == 8'h00) |-> kprod_o == 8'h00);
  end else begin : g_cmb
    always_comb begin
      if (b_i == 8'h01)
        a_r10_ident: assert (prod_o == a_i) else $error("identity");
      if (a_i == 8'h00)
        a_r10_zero: assert (prod_o == 8'h00 && kprod_o == 8'h00) else $error("zero");
      a_r10_valid: assert (valid_o == valid_i) else $error("valid pass");
    end
  end
endmodule

bind tgf_mul tgf_mul_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
  .prod_c(prod_c), .prod_o(prod_o), .kprod_o(kprod_o), .valid_o(valid_o)
);

// File: tb/tgf_mul_tb.sv
module tgf_mul_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [7:0] pr, kpr, pc, kpc;
  logic vr, vc;
  int total = 0, bad = 0;
  logic [7:0] table_q [65536];

  always #10 clk = ~clk; // 50 MHz

  tgf_mul #(.REG_OUT(1'b1), .KCONST(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .a_i(a), .b_i(b),
    .prod_o(pr), .kprod_o(kpr), .valid_o(vr));
  tgf_mul #(.REG_OUT(1'b0), .KCONST(3)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .a_i(a), .b_i(b),
    .prod_o(pc), .kprod_o(kpc), .valid_o(vc));

  // schoolbook reference, generic reduction at every level
  function automatic logic [1:0] r4(input logic [1:0] x, input logic [1:0] y);
    logic p0, p1, p2;
    p0 = x[0] & y[0];
    p1 = (x[0] & y[1]) ^ (x[1] & y[0]);
    p2 = x[1] & y[1];
    return {p1 ^ p2, p0 ^ p2};
  endfunction
  function automatic logic [3:0] r16(input logic [3:0] x, input logic [3:0] y);
    logic [1:0] p0, p1, p2;
    p0 = r4(x[1:0], y[1:0]);
    p1 = r4(x[1:0], y[3:2]) ^ r4(x[3:2], y[1:0]);
    p2 = r4(x[3:2], y[3:2]);
    return {p1 ^ p2, p0 ^ r4(p2, 2'b10)};
  endfunction
  function automatic logic [7:0] r256(input logic [7:0] x, input logic [7:0] y);
    logic [3:0] p0, p1, p2;
    p0 = r16(x[3:0], y[3:0]);
    p1 = r16(x[3:0], y[7:4]) ^ r16(x[7:4], y[3:0]);
    p2 = r16(x[7:4], y[7:4]);
    return {p1 ^ p2, p0 ^ r16(p2, 4'h8)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic put(input logic v, input logic [7:0] x, input logic [7:0] y);
    vld = v; a = x; b = y;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pa, pb, held;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 prod reset", pr, 8'h00);
    chk("R11 kprod reset", kpr, 8'h00);
    chk("R11 valid reset", {7'd0, vr}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R4 basis rules on both variants
    put(1'b1, 8'h02, 8'h02);
    chk("R2 comb w*w", pc, 8'h03);
    @(negedge clk); chk("R2 reg w*w", pr, 8'h03);
    chk("R9 valid high", {7'd0, vr}, 8'h01);
    put(1'b1, 8'h04, 8'h04);
    chk("R3 comb y*y", pc, 8'h06);
    @(negedge clk); chk("R3 reg y*y", pr, 8'h06);
    put(1'b1, 8'h10, 8'h10);
    chk("R4 comb z*z", pc, 8'h18);
    @(negedge clk); chk("R4 reg z*z", pr, 8'h18);
    put(1'b1, 8'h01, 8'h10);
    chk("R1 one is identity", pc, 8'h10);
    @(negedge clk);

    // R9 hold while valid low
    held = pr;
    put(1'b0, 8'h57, 8'hA3);
    chk("R10 valid passthrough", {7'd0, vc}, 8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 hold prod", pr, held);
      chk("R9 hold kprod", kpr, r256(8'h01, 8'h02));
      chk("R9 valid low", {7'd0, vr}, 8'h00);
      put(1'b0, 8'(i * 37 + 5), 8'(i * 91 + 3));
    end

    // R5, R7, R8, R10 exhaustive sweep, pipelined
    pa = 8'h00; pb = 8'h00;
    for (int k = 0; k < 65536; k++) begin
      logic [7:0] x, y;
      x = k[15:8]; y = k[7:0];
      put(1'b1, x, y);
      chk("R5 comb product", pc, r256(x, y));
      chk("R8 comb constant w+1", kpc, r256(x, 8'h03));
      if (x == 8'h00 || y == 8'h00) chk("R7 zero", pc, 8'h00);
      if (y == 8'h01) chk("R7 identity", pc, x);
      table_q[k] = pc;
      @(negedge clk);
      chk("R5 reg product", pr, r256(x, y));
      chk("R8 reg constant w", kpr, r256(x, 8'h02));
      pa = x; pb = y;
    end
    vld = 1'b0;

    // R6 commutativity from the recorded table
    for (int x = 0; x < 256; x++) begin
      for (int y = x + 1; y < 256; y++) begin
        chk("R6 commutative", table_q[x * 256 + y], table_q[y * 256 + x]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule